// File: doc/BRIEF.md
# Byte-Banked Interrupt Aggregator

This block gathers a wide set of interrupt requests from peripherals into one summary line for a host processor. The requests are split into byte-sized banks. Each bank has a mask register that software can read and write, and a status view that software can only read. Software reads a status byte and gets the pending requests that are enabled, and that read also acknowledges them. The summary output is registered, so the host can detect it as a clean rising edge.

Every request except one is treated as an event. A rising edge on an enabled input sets a sticky pending bit, and a read of that bank's status clears it. The one remaining input, chosen by a parameter, is a level request. Its status bit follows the synchronized request level and a read does not change it. An edge that arrives while its input is masked is dropped. A request that is already high when its input is unmasked therefore raises nothing until it gives a new edge. Every request passes through a two-flop synchronizer before any edge is detected.

The register port is byte wide, with an address, a read strobe, a write strobe and a write data bus. Read data is registered: it appears in the cycle after the read strobe and then holds until the next read. Bank b has its status at offset 2b and its mask at offset 2b+1.

Top module: `byte_irq_hub`

## Requirements
- R1: While reset is asserted, and after it is released, every mask register is 0, every edge status bit is 0, and irq_o and rd_data_o are 0.
- R2: A write strobe at offset 2b+1 loads wr_data_i into the mask of bank b. A read at that offset returns the mask in the next cycle.
- R3: A rising edge on an enabled edge request sets its status bit. Request index i maps to bank i/8, bit i%8. The bit is set two clock edges after the first clock edge that samples the request high.
- R4: A rising edge seen while the mask bit of its input is 0 sets nothing. A request that is already high when its mask bit is set to 1 sets nothing.
- R5: A read at offset 2b returns, one cycle later, the status of bank b ANDed with its mask. That read clears every edge status bit of bank b and leaves the other banks unchanged.
- R6: If a rising edge reaches capture on the same clock edge as a status read of its bank, the read returns the value from before that edge, and the new bit stays pending.
- R7: The level request (default index 2) shows its synchronized level in its status bit, and a status read does not clear that bit.
- R8: irq_o is 1 exactly in the cycle after one in which any status bit ANDed with its mask is 1.
- R9: Writes to status offsets change nothing. Reads at offsets with no register (6 and 7) return 0.
- R10: Clearing a mask bit hides its pending edge from irq_o and from reads without discarding it. Setting the mask bit again brings the pending edge back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 24 | Asynchronous interrupt requests |
| addr_i | input | 3 | Register byte offset |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The hardest case to reach is R6, where an edge reaches capture on the very clock edge at which software reads and clears its bank. The stimulus raises the request at a falling edge and counts the two synchronizer stages. It then places the read strobe so that the capture edge and the read edge coincide, and checks that the read returns the old value and that a second read shows the new bit. A behavioural model compares rd_data_o and irq_o on every cycle, so masked-edge and unmask-while-high cases are checked cycle by cycle, not only at their end points.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  // Bank addressed by a byte offset: two registers per bank.
  function automatic int bank_of_addr(int addr);
    return addr / 2;
  endfunction

  // Odd offsets hold masks, even offsets hold status.
  function automatic bit addr_is_mask(int addr);
    return (addr % 2) == 1;
  endfunction

  // Bank that holds a given request index.
  function automatic int bank_of_req(int idx, int bank_w);
    return idx / bank_w;
  endfunction

  // Bit position of a request inside its bank.
  function automatic int pos_of_req(int idx, int bank_w);
    return idx % bank_w;
  endfunction

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] stab_q;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= req_i;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign lvl_o  = stab_q;
  assign rise_o = stab_q & ~prev_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W       = 8,
  parameter bit LVL_EN  = 1'b0,
  parameter int LVL_POS = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] lvl_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         stat_rd_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] pend_o
);
  localparam logic [W-1:0] EDGE_ONLY = LVL_EN ? ~(W'(1) << LVL_POS) : '1;

  logic [W-1:0] mask_q;
  logic [W-1:0] edge_q;
  logic [W-1:0] view;

  // Keep-then-clear, then set: a capture on a read edge survives.
  function automatic logic [W-1:0] next_edges(logic [W-1:0] cur, logic clr,
                                              logic [W-1:0] rise, logic [W-1:0] en);
    logic [W-1:0] kept;
    kept = clr ? '0 : cur;
    return kept | (rise & en & EDGE_ONLY);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      edge_q <= '0;
    end else begin
      edge_q <= next_edges(edge_q, stat_rd_i, rise_i, mask_q);
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign view   = (edge_q & EDGE_ONLY) | (lvl_i & ~EDGE_ONLY);
  assign mask_o = mask_q;
  assign edge_o = edge_q;
  assign pend_o = view & mask_q;
endmodule

// File: rtl/byte_irq_hub.sv
module byte_irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int LEVEL_IDX = 2,
  parameter int ADDR_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   req_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          rd_en_i,
  input  logic                          wr_en_i,
  input  logic [BANK_W-1:0]             wr_data_i,
  output logic [BANK_W-1:0]             rd_data_o,
  output logic                          irq_o
);
  localparam int TOTAL   = NUM_BANKS * BANK_W;
  localparam int LVL_BNK = bank_of_req(LEVEL_IDX, BANK_W);
  localparam int LVL_POS = pos_of_req(LEVEL_IDX, BANK_W);
  localparam logic [TOTAL-1:0] EDGE_ONLY = ~(TOTAL'(1) << LEVEL_IDX);

  // Named internal events, brought out for the checker.
  logic [TOTAL-1:0]     rise_vec;
  logic [TOTAL-1:0]     lvl_vec;
  logic [TOTAL-1:0]     mask_vec;
  logic [TOTAL-1:0]     edge_stat;
  logic [TOTAL-1:0]     pend_vec;
  logic [TOTAL-1:0]     cap_vec;
  logic [NUM_BANKS-1:0] stat_rd;
  logic [NUM_BANKS-1:0] mask_wr;
  logic                 pend_any;

  logic [BANK_W-1:0] mask_bank [NUM_BANKS];
  logic [BANK_W-1:0] pend_bank [NUM_BANKS];
  logic [BANK_W-1:0] rd_sel;
  logic [BANK_W-1:0] rd_q;
  logic              irq_q;

  irq_req_sync #(.N(TOTAL)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .lvl_o  (lvl_vec),
    .rise_o (rise_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign stat_rd[b] = rd_en_i && (int'(addr_i) == 2 * b);
    assign mask_wr[b] = wr_en_i && (int'(addr_i) == 2 * b + 1);

    irq_bank #(
      .W       (BANK_W),
      .LVL_EN  (LVL_BNK == b),
      .LVL_POS ((LVL_BNK == b) ? LVL_POS : 0)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise_vec[b*BANK_W +: BANK_W]),
      .lvl_i     (lvl_vec[b*BANK_W +: BANK_W]),
      .mask_we_i (mask_wr[b]),
      .wdata_i   (wr_data_i),
      .stat_rd_i (stat_rd[b]),
      .mask_o    (mask_bank[b]),
      .edge_o    (edge_stat[b*BANK_W +: BANK_W]),
      .pend_o    (pend_bank[b])
    );

    assign mask_vec[b*BANK_W +: BANK_W] = mask_bank[b];
    assign pend_vec[b*BANK_W +: BANK_W] = pend_bank[b];
  end

  assign cap_vec  = rise_vec & mask_vec & EDGE_ONLY;
  assign pend_any = |pend_vec;

  always_comb begin
    rd_sel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_of_addr(int'(addr_i)) == b)
        rd_sel = addr_is_mask(int'(addr_i)) ? mask_bank[b] : pend_bank[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= pend_any;
      if (rd_en_i) rd_q <= rd_sel;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        irq_o,
  input logic                        pend_any,
  input logic [NUM_BANKS*BANK_W-1:0] mask_vec,
  input logic [NUM_BANKS*BANK_W-1:0] edge_stat,
  input logic [NUM_BANKS*BANK_W-1:0] cap_vec,
  input logic [NUM_BANKS-1:0]        stat_rd
);
  // R1: reset holds the summary low
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> (irq_o == 1'b0));

  // R8: summary follows pending one cycle later
  assert_summary_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |=> irq_o);
  assert_summary_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_any |=> !irq_o);

  // R4: a newly set edge bit had its mask enabled
  assert_masked_edge_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_stat & ~$past(edge_stat) & ~$past(mask_vec)) == '0));

  // R3, R6: every qualified capture lands, even on a read edge
  assert_capture_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_stat & $past(cap_vec)) == $past(cap_vec)));

  // R5: a status read with no capture empties its bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd[b] && (cap_vec[b*BANK_W +: BANK_W] == '0))
      |=> (edge_stat[b*BANK_W +: BANK_W] == '0));
  end
endmodule

bind byte_irq_hub irq_hub_checker #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .pend_any  (pend_any),
  .mask_vec  (mask_vec),
  .edge_stat (edge_stat),
  .cap_vec   (cap_vec),
  .stat_rd   (stat_rd)
);

// File: tb/tb_byte_irq_hub.sv
`timescale 1ns/1ps
module tb_byte_irq_hub;
  localparam int LVL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] req = '0;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_irq_hub dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // Behavioural reference: history queue of sampled requests, sticky bits.
  logic [23:0] hist [$] = '{24'h0, 24'h0, 24'h0};
  logic [23:0] m_edge = '0;
  logic [23:0] m_mask = '0;
  logic [7:0]  m_rd = '0;
  logic        m_irq = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{24'h0, 24'h0, 24'h0};
      m_edge = '0; m_mask = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      logic [23:0] lvl, rise, view, pend;
      int a, bk;
      lvl  = hist[1];
      rise = hist[1] & ~hist[2];
      view = m_edge;
      view[LVL] = lvl[LVL];
      pend = view & m_mask;
      a  = int'(addr);
      bk = a / 2;
      m_irq = (pend != 0);
      if (rd_en) begin
        if (bk < 3) m_rd = (a % 2 == 1) ? m_mask[bk*8 +: 8] : pend[bk*8 +: 8];
        else        m_rd = 8'h00;
        if (bk < 3 && a % 2 == 0) m_edge[bk*8 +: 8] = 8'h00;
      end
      for (int i = 0; i < 24; i++)
        if (i != LVL && rise[i] && m_mask[i]) m_edge[i] = 1'b1;
      if (wr_en && bk < 3 && a % 2 == 1) m_mask[bk*8 +: 8] = wdata;
      hist.push_front(req);
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R5, R8 and all others).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 model rd_data", rd_data, m_rd);
      check("R8 model irq", {7'b0, irq}, {7'b0, m_irq});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); req[idx] = 1'b1;
    repeat (2) @(negedge clk);
    req[idx] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    wait_n(3);
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    check("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    wait_n(2);
    rd(3'd1, d); check("R1 mask low", d, 8'h00);
    rd(3'd5, d); check("R1 mask third", d, 8'h00);
    rd(3'd0, d); check("R1 status low", d, 8'h00);

    // R2 mask write/read
    wr(3'd1, 8'hFB); wr(3'd3, 8'h0F); wr(3'd5, 8'hA5);
    rd(3'd1, d); check("R2 mask low", d, 8'hFB);
    rd(3'd3, d); check("R2 mask high", d, 8'h0F);
    rd(3'd5, d); check("R2 mask third", d, 8'hA5);

    // R3 / R8 edge capture and summary
    pulse(0);
    check("R8 irq after edge", {7'b0, irq}, 8'h01);
    rd(3'd0, d); check("R3 status low bit0", d, 8'h01);
    rd(3'd0, d); check("R5 cleared by read", d, 8'h00);
    wait_n(1);
    check("R8 irq low after clear", {7'b0, irq}, 8'h00);

    // R4 masked edge, then high while unmasked
    pulse(12);
    wr(3'd3, 8'hFF);
    rd(3'd2, d); check("R4 masked edge dropped", d, 8'h00);
    wr(3'd3, 8'h0F);
    @(negedge clk); req[13] = 1'b1;
    wait_n(4);
    wr(3'd3, 8'hFF);
    wait_n(3);
    rd(3'd2, d); check("R4 high before unmask", d, 8'h00);
    check("R4 irq stays low", {7'b0, irq}, 8'h00);
    @(negedge clk); req[13] = 1'b0;
    wait_n(3);

    // R5 read clears own bank only
    pulse(1); pulse(16);
    rd(3'd0, d); check("R5 low bank", d, 8'h02);
    rd(3'd4, d); check("R5 third bank kept", d, 8'h01);
    rd(3'd4, d); check("R5 third cleared", d, 8'h00);

    // R7 level input
    wr(3'd1, 8'hFF);
    @(negedge clk); req[LVL] = 1'b1;
    wait_n(3);
    check("R7 irq from level", {7'b0, irq}, 8'h01);
    rd(3'd0, d); check("R7 level seen", d, 8'h04);
    rd(3'd0, d); check("R7 level not cleared", d, 8'h04);
    @(negedge clk); req[LVL] = 1'b0;
    wait_n(3);
    rd(3'd0, d); check("R7 level follows low", d, 8'h00);

    // R6 edge coincident with read
    @(negedge clk); req[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 3'd0; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
    check("R6 read returns old value", d, 8'h00);
    rd(3'd0, d); check("R6 edge kept pending", d, 8'h08);
    req[3] = 1'b0;
    wait_n(3);

    // R9 writes to status ignored, unused offsets read 0
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd0, d); check("R9 status write ignored", d, 8'h00);
    rd(3'd1, d); check("R9 mask unchanged", d, 8'hFF);
    rd(3'd6, d); check("R9 unused offset 6", d, 8'h00);
    rd(3'd7, d); check("R9 unused offset 7", d, 8'h00);

    // R10 masking hides but keeps
    pulse(4);
    wr(3'd1, 8'hEF);
    wait_n(2);
    check("R10 irq hidden", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'hFF);
    wait_n(2);
    check("R10 irq back", {7'b0, irq}, 8'h01);
    rd(3'd0, d); check("R10 pending kept", d, 8'h10);

    // R3 high bank bit position
    pulse(9);
    rd(3'd2, d); check("R3 high bank bit1", d, 8'h02);
    wait_n(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule